// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software with a 7-bit down-counter. Software has to refresh the counter at the right time. A refresh that comes too late lets the counter fall out of its upper half. A refresh that comes too early arrives while the count is still above a programmable window value. In either case, once the watchdog is armed, the block issues a one-cycle system reset pulse.

The counter steps down on a tick. The tick comes from a fixed power-of-two divider of the bus clock, followed by a software-selected extra divide of 1, 2, 4 or 8. The counter runs all the time. Arming the watchdog only decides whether its events may reset the system. When the count reaches the halfway mark, a warning flag is set. That flag can drive an interrupt, so software gets a last chance to refresh.

Software reaches three registers through a plain address / write-enable / write-data / read-data port:

| Register | Offset | Fields |
|---|---|---|
| Control | 0x00 | arm bit [7], count [6:0] |
| Configuration | 0x04 | interrupt enable [9], divide select [8:7], window [6:0] |
| Status | 0x08 | warning flag [0] |

Read data is registered. Everything runs on one clock.

Top module: `win_wdog_top`

## Requirements
- R1: While armed, a decrement of the count from 0x40 to 0x3F produces a reset pulse on `sys_rst_o` in the cycle after that tick edge.
- R2: A control write produces a reset pulse in the next cycle if both of these hold: the count before the write is greater than the window value, and the watchdog is armed or the written bit 7 is 1. A control write with the count at or below the window produces no pulse and loads the count from write data bits [6:0].
- R3: The count decrements once every 2^(FIX_LOG2+S) clock cycles, where S is configuration bits [8:7].
- R4: While not armed, the count keeps decrementing and wraps past 0x3F without any reset pulse.
- R5: The arm bit (control bit 7) is set by writing 1 to it. Writing 0 to it leaves it at 1. Only a reset clears it.
- R6: A control write with bit 7 = 1 and bit 6 = 0 gives a reset pulse in the next cycle. The same bit 6 = 0 write while not armed and with bit 7 = 0 gives none.
- R7: The warning flag (status bit 0) is set when the count decrements to 0x40, whether or not the interrupt is enabled. Writing 0 to status bit 0 clears it, and writing 1 to it has no effect.
- R8: `irq_o` is high exactly when the interrupt enable (configuration bit 9) and the warning flag are both set. The enable is set-only, so writing 0 to bit 9 keeps it at 1.
- R9: After reset, reads return 0x7F at offset 0x00, 0x7F at 0x04 and 0x00 at 0x08. `rdata_o` shows the addressed register one cycle after the address is presented.
- R10: `sys_rst_o` is high for exactly one cycle. After that cycle, every register, the count and the divider are back at their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| sys_rst_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | Early-warning interrupt |

## Verification
The reset pulse is due in the cycle right after the edge that takes the offending write or the 0x40 tick. The bench samples `sys_rst_o` at the falling edge that follows that clock edge, and samples it once more one cycle later to confirm the pulse has ended. Read data trails its address by one edge. Each read therefore sets the address at a falling edge and compares at the next falling edge. The flag and `irq_o` rise on the same edge as the 0x41-to-0x40 tick. The bench checks that the gap between the interrupt and the timeout pulse is exactly one tick period. Tick periods are measured between the second and third count changes after the divide select is written, so the partial first period after the write is not counted.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // register byte offsets
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_CFG  = 8'h04;
  localparam logic [7:0] OFS_STAT = 8'h08;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int FIX_LOG2 = 12,
  parameter int TB_W     = 2
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [TB_W-1:0] tb_i,
  output logic            tick_o
);
  localparam int TB_MAX = (1 << TB_W) - 1;
  localparam int PRE_W  = FIX_LOG2 + TB_MAX;
  localparam logic [TB_W-1:0] TB_TOP = '1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic [TB_W-1:0]  shift;

  // free-running divider, never cleared by a refresh
  always_ff @(posedge clk_i) begin
    if (rst_i) pre_q <= '0;
    else       pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    shift  = TB_TOP - tb_i;
    mask   = {PRE_W{1'b1}} >> shift;
    tick_o = &(pre_q | ~mask);
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       cnt_q <= '1;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int TB_W   = 2,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              en_o,
  output logic              ewi_o,
  output logic [TB_W-1:0]   tb_o,
  output logic [CNT_W-1:0]  win_o,
  output logic              flag_o,
  output logic              irq_o,
  output logic              wr_ctrl_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int EN_BIT  = CNT_W;
  localparam int TB_LO   = CNT_W;
  localparam int EWI_BIT = CNT_W + TB_W;
  localparam logic [CNT_W-1:0] MARK    = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] MARK_P1 = MARK + 1'b1;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  reg_sel_e          sel;
  logic              en_q, ewi_q, flag_q, irq_q;
  logic [TB_W-1:0]   tb_q;
  logic [CNT_W-1:0]  win_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  logic              wr_ctrl, wr_cfg, wr_stat;
  logic              flag_set, flag_d, ewi_d;

  always_comb begin
    if (addr_i == A_CTRL)      sel = SEL_CTRL;
    else if (addr_i == A_CFG)  sel = SEL_CFG;
    else if (addr_i == A_STAT) sel = SEL_STAT;
    else                       sel = SEL_NONE;
  end

  assign wr_ctrl = wr_en_i && (sel == SEL_CTRL);
  assign wr_cfg  = wr_en_i && (sel == SEL_CFG);
  assign wr_stat = wr_en_i && (sel == SEL_STAT);

  // flag rises on the decrement into the halfway mark; a set beats a clear
  assign flag_set = tick_i && !wr_ctrl && (cnt_i == MARK_P1);
  assign flag_d   = flag_set || (flag_q && !(wr_stat && !wdata_i[0]));
  assign ewi_d    = ewi_q || (wr_cfg && wdata_i[EWI_BIT]);

  always_comb begin
    case (sel)
      SEL_CTRL: rd_mux = DATA_W'({en_q, cnt_i});
      SEL_CFG:  rd_mux = DATA_W'({ewi_q, tb_q, win_q});
      SEL_STAT: rd_mux = DATA_W'(flag_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_q    <= 1'b0;
      ewi_q   <= 1'b0;
      tb_q    <= '0;
      win_q   <= '1;
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      en_q <= en_q || (wr_ctrl && wdata_i[EN_BIT]);
      if (wr_cfg) begin
        tb_q  <= wdata_i[TB_LO +: TB_W];
        win_q <= wdata_i[CNT_W-1:0];
      end
      ewi_q   <= ewi_d;
      flag_q  <= flag_d;
      irq_q   <= ewi_d && flag_d;
      rdata_q <= rd_mux;
    end
  end

  assign en_o      = en_q;
  assign ewi_o     = ewi_q;
  assign tb_o      = tb_q;
  assign win_o     = win_q;
  assign flag_o    = flag_q;
  assign irq_o     = irq_q;
  assign wr_ctrl_o = wr_ctrl;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/win_wdog_top.sv
module win_wdog_top #(
  parameter int FIX_LOG2 = 12,
  parameter int CNT_W    = 7,
  parameter int TB_W     = 2,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sys_rst_o,
  output logic              irq_o
);
  localparam logic [CNT_W-1:0] MARK = {1'b1, {(CNT_W-1){1'b0}}};

  logic             rst_int;
  logic             tick;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] win_q;
  logic [TB_W-1:0]  tb_q;
  logic             en_q, ewi_q, flag_q, wr_ctrl;
  logic             en_eff, win_bad, sw_rst, tmo, rst_req;
  logic             sys_rst_q;

  // the block resets itself on the cycle after its own pulse
  assign rst_int = rst_i || sys_rst_q;

  wdog_prescaler #(.FIX_LOG2(FIX_LOG2), .TB_W(TB_W)) u_pre (
    .clk_i (clk_i),
    .rst_i (rst_int),
    .tb_i  (tb_q),
    .tick_o(tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_i     (rst_int),
    .tick_i    (tick),
    .load_i    (wr_ctrl),
    .load_val_i(wdata_i[CNT_W-1:0]),
    .cnt_o     (cnt_q)
  );

  wdog_regs #(.CNT_W(CNT_W), .TB_W(TB_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_i    (rst_int),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .tick_i   (tick),
    .cnt_i    (cnt_q),
    .en_o     (en_q),
    .ewi_o    (ewi_q),
    .tb_o     (tb_q),
    .win_o    (win_q),
    .flag_o   (flag_q),
    .irq_o    (irq_o),
    .wr_ctrl_o(wr_ctrl),
    .rdata_o  (rdata_o)
  );

  // a write that arms the block is judged as armed
  always_comb begin
    en_eff  = en_q || wdata_i[CNT_W];
    win_bad = wr_ctrl && en_eff && (cnt_q > win_q);
    sw_rst  = wr_ctrl && en_eff && !wdata_i[CNT_W-1];
    tmo     = en_q && tick && !wr_ctrl && (cnt_q == MARK);
    rst_req = win_bad || sw_rst || tmo;
  end

  always_ff @(posedge clk_i) begin
    if (rst_int) sys_rst_q <= 1'b0;
    else         sys_rst_q <= rst_req;
  end

  assign sys_rst_o = sys_rst_q;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             wr_en_i,
  input logic             wr_ctrl,
  input logic             tick,
  input logic             en_q,
  input logic             ewi_q,
  input logic             flag_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] win_q,
  input logic             sys_rst_o,
  input logic             irq_o
);
  localparam logic [CNT_W-1:0] MARK    = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] MARK_P1 = MARK + 1'b1;

  // R10
  rst_one_cycle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    sys_rst_o |=> !sys_rst_o);

  // R1
  timeout_rst_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!sys_rst_o && en_q && tick && !wr_ctrl && cnt_q == MARK) |=> sys_rst_o);

  // R2
  early_refresh_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!sys_rst_o && wr_ctrl && en_q && cnt_q > win_q) |=> sys_rst_o);

  // R4
  idle_no_rst_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!sys_rst_o && !en_q && !wr_en_i) |=> !sys_rst_o);

  // R5
  arm_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_q && !sys_rst_o) |=> en_q);

  // R7
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!sys_rst_o && tick && !wr_ctrl && cnt_q == MARK_P1) |=> flag_q);

  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o |-> (ewi_q && flag_q));
endmodule

bind win_wdog_top wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .wr_en_i  (wr_en_i),
  .wr_ctrl  (wr_ctrl),
  .tick     (tick),
  .en_q     (en_q),
  .ewi_q    (ewi_q),
  .flag_q   (flag_q),
  .cnt_q    (cnt_q),
  .win_q    (win_q),
  .sys_rst_o(sys_rst_o),
  .irq_o    (irq_o)
);

// File: tb/win_wdog_top_test.sv
`timescale 1ns/1ps
module win_wdog_top_test;
  localparam int FIX = 2;
  localparam int AW  = 4;
  localparam int DW  = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          sys_rst, irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int pulses = 0;

  always #5 clk = ~clk;

  win_wdog_top #(.FIX_LOG2(FIX), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sys_rst_o(sys_rst), .irq_o(irq)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (sys_rst) pulses <= pulses + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; wr_en = 1'b0; addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a[AW-1:0]; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a[AW-1:0];
    @(negedge clk); d = rdata;
  endtask

  task automatic t_reset_vals();
    logic [31:0] d;
    do_reset();
    rd(8'h00, d); check("R9 ctrl reset", d, 32'h7F);
    rd(8'h04, d); check("R9 cfg reset", d, 32'h7F);
    rd(8'h08, d); check("R9 status reset", d, 32'h0);
    check("R8 irq low after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_period(input int s);
    logic [31:0] d, prev;
    int chg, t1, t2;
    do_reset();
    wr(8'h04, 32'h7F | (s << 7));
    chg = 0; t1 = 0; t2 = 0;
    rd(8'h00, prev);
    for (int i = 0; i < 200 && chg < 3; i++) begin
      @(negedge clk); d = rdata;
      if (d != prev) begin
        chg++;
        if (chg == 2) t1 = i;
        if (chg == 3) t2 = i;
      end
      prev = d;
    end
    check("R3 tick period", t2 - t1, 32'(1 << (FIX + s)));
  endtask

  task automatic t_idle_run();
    logic [31:0] d;
    int p0;
    do_reset();
    p0 = pulses;
    wr(8'h00, 32'h3F);
    repeat (2) @(negedge clk);
    check("R6 bit6 clear while unarmed gives no pulse", pulses - p0, 0);
    wr(8'h00, 32'h42);
    repeat (40) @(negedge clk);
    check("R4 no pulse while unarmed", pulses - p0, 0);
    rd(8'h00, d);
    check("R4 count below 0x40 and unarmed", {31'b0, (d < 32'h40)}, 32'h1);
    rd(8'h08, d); check("R7 flag set without irq enable", d, 32'h1);
    check("R8 irq stays low when disabled", {31'b0, irq}, 32'h0);
    wr(8'h08, 32'h1);
    rd(8'h08, d); check("R7 write 1 keeps flag", d, 32'h1);
    wr(8'h08, 32'h0);
    rd(8'h08, d); check("R7 write 0 clears flag", d, 32'h0);
  endtask

  task automatic t_arm_sticky();
    logic [31:0] d;
    int p0;
    do_reset();
    p0 = pulses;
    wr(8'h00, 32'hFF);
    rd(8'h00, d); check("R5 arm bit set", d[7], 1);
    wr(8'h00, 32'h7F);
    rd(8'h00, d); check("R5 arm bit kept after writing 0", d[7], 1);
    check("R5 no pulse for in-window refresh", pulses - p0, 0);
  endtask

  task automatic t_soft();
    logic [31:0] d;
    do_reset();
    wr(8'h04, 32'h27F);
    wr(8'h00, 32'hFF);
    wr(8'h00, 32'hBF);
    check("R6 software reset pulse", {31'b0, sys_rst}, 32'h1);
    @(negedge clk);
    check("R10 pulse ends after one cycle", {31'b0, sys_rst}, 32'h0);
    rd(8'h00, d); check("R10 ctrl back to reset", d, 32'h7F);
    rd(8'h04, d); check("R10 cfg back to reset", d, 32'h7F);
    rd(8'h08, d); check("R10 status back to reset", d, 32'h0);
  endtask

  task automatic t_window();
    logic [31:0] d;
    int p0;
    do_reset();
    wr(8'h00, 32'hFF);
    wr(8'h04, 32'h50);
    wr(8'h00, 32'hFF);
    check("R2 early refresh pulse", {31'b0, sys_rst}, 32'h1);
    do_reset();
    wr(8'h00, 32'hFF);
    wr(8'h04, 32'h50);
    d = 32'h7F;
    for (int i = 0; i < 400 && d[6:0] >= 7'h50; i++) rd(8'h00, d);
    p0 = pulses;
    wr(8'h00, 32'hFF);
    @(negedge clk);
    check("R2 in-window refresh gives no pulse", pulses - p0, 0);
    rd(8'h00, d);
    check("R2 refresh reloads count", {31'b0, (d[6:0] >= 7'h7E && d[7])}, 32'h1);
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    int t_irq, t_rst, width;
    do_reset();
    wr(8'h04, 32'h27F);
    wr(8'h04, 32'h07F);
    rd(8'h04, d); check("R8 irq enable is set-only", d, 32'h27F);
    wr(8'h00, 32'hC2);
    t_irq = -1; t_rst = -1; width = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (irq && t_irq < 0) t_irq = i;
      if (sys_rst) begin
        width++;
        if (t_rst < 0) t_rst = i;
      end
    end
    check("R1 timeout pulse seen", {31'b0, (t_rst >= 0)}, 32'h1);
    check("R8 irq raised at 0x40", {31'b0, (t_irq >= 0)}, 32'h1);
    check("R1 pulse one tick after the 0x40 mark", t_rst - t_irq, 32'(1 << FIX));
    check("R10 pulse width", width, 1);
    check("R10 irq cleared by self reset", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    t_reset_vals();
    for (int s = 0; s < 4; s++) t_period(s);
    t_idle_run();
    t_arm_sticky();
    t_soft();
    t_window();
    t_timeout();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule